// File: doc/BRIEF.md
# Polled Command Port Controller

This block is the device-side end of a host I/O port that runs a busy/command-ready handshake through registers. The host sees four byte-wide registers on a simple synchronous bus: a status word, a command (control) word, an outgoing data byte and an incoming data byte. The host polls status until the controller is idle. It then loads the outgoing byte and writes a command word that carries both the transfer direction and the go flag.

Once the go flag is latched, the controller marks itself busy and raises a single-byte request toward the device. The request uses a valid/ready handshake, and the device's response byte and failure flag are sampled in the handshake cycle. In that same clock edge the controller finishes the command: busy and command-ready drop together and the error flag takes the device's failure flag. A successful read also deposits the response byte in the incoming data register.

Top module: `cmd_port_ctrl`

## Requirements
- R1: After a synchronous reset, every status flag is 0, the read data output is 0, and no device request is raised.
- R2: The register map is as follows. Offset 0 is status: bit 0 busy, bit 1 command-ready, bit 2 error, all other bits 0. Offset 1 is the command word: bit 0 direction, where 1 means write to the device and 0 means read from it; bit 1 is go/command-ready. Offset 2 is the outgoing data byte. Offset 3 is the incoming data byte. A read strobe returns the addressed value on the read data output one clock later.
- R3: A host write to offset 1 with bit 1 set sets command-ready. On the next clock the controller sets busy and raises the device request.
- R4: For a write command, the device request has direction 1 and carries the byte held in the outgoing data register.
- R5: For a read command, the device request has direction 0. On a handshake without failure, the response byte is stored in the incoming data register.
- R6: On the clock edge where request valid and ready are both high, busy and command-ready clear together and error takes the device failure flag. A successful command therefore clears an earlier error.
- R7: A failed command sets error. A failed read leaves the incoming data register unchanged.
- R8: Host writes to offset 1 or offset 2 have no effect while busy or command-ready is set.
- R9: Host writes to offsets 0 and 3 never change any register.
- R10: While the device holds ready low, the request stays valid and its direction and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 2 | Register offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| dev_req_valid | output | 1 | Device request valid |
| dev_req_write | output | 1 | Request direction, 1 = to device |
| dev_req_data | output | DATA_W | Byte sent to the device |
| dev_req_ready | input | 1 | Device accepts/finishes the transfer |
| dev_rsp_data | input | DATA_W | Byte returned by the device |
| dev_rsp_err | input | 1 | Device failure flag, sampled on handshake |

## Verification
The hardest window to reach is the one clock in which command-ready is already set but busy has not yet risen. A write to the outgoing byte during that clock must be dropped, even though busy still reads 0. The stimulus reaches it by issuing a data write on the clock right after the go write, and then issues a command overwrite while the device stub holds ready low for several cycles. A random phase then mixes reads, writes, go commands and device delays and failures, and a behavioural reference model is compared against the device and read ports on every cycle.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_TXB    = 2'd2;
  localparam logic [ADDR_W-1:0] OFF_RXB    = 2'd3;

  localparam int ST_BUSY = 0;
  localparam int ST_RDY  = 1;
  localparam int ST_ERR  = 2;

  localparam int CMD_DIR = 0;
  localparam int CMD_GO  = 1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_XFER = 1'b1
  } seq_state_t;
endpackage

// File: rtl/cpc_regs.sv
module cpc_regs
  import cpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_err,
  input  logic              load_rx,
  input  logic [DATA_W-1:0] rx_val,
  output logic              cmd_rdy,
  output logic              cmd_dir,
  output logic [DATA_W-1:0] tx_byte,
  output logic              err_flag
);
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] cmd_w;
  logic [DATA_W-1:0] rd_mux;
  logic              locked;
  logic              wr_ok;

  assign locked = busy | cmd_rdy;
  assign wr_ok  = host_we & ~locked;

  always_comb begin
    status_w          = '0;
    status_w[ST_BUSY] = busy;
    status_w[ST_RDY]  = cmd_rdy;
    status_w[ST_ERR]  = err_flag;
    cmd_w             = '0;
    cmd_w[CMD_DIR]    = cmd_dir;
    cmd_w[CMD_GO]     = cmd_rdy;
  end

  always_comb begin
    unique case (host_addr)
      OFF_STATUS: rd_mux = status_w;
      OFF_CMD:    rd_mux = cmd_w;
      OFF_TXB:    rd_mux = tx_byte;
      default:    rd_mux = rx_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      host_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_rdy <= 1'b0;
      cmd_dir <= 1'b0;
    end else if (done) begin
      cmd_rdy <= 1'b0;
    end else if (wr_ok && host_addr == OFF_CMD) begin
      cmd_rdy <= host_wdata[CMD_GO];
      cmd_dir <= host_wdata[CMD_DIR];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte <= '0;
    end else if (wr_ok && host_addr == OFF_TXB) begin
      tx_byte <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte  <= '0;
      err_flag <= 1'b0;
    end else if (done) begin
      err_flag <= done_err;
      if (load_rx) begin
        rx_byte <= rx_val;
      end
    end
  end
endmodule

// File: rtl/cpc_seq.sv
module cpc_seq
  import cpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rdy,
  input  logic              cmd_dir,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic              load_rx,
  output logic [DATA_W-1:0] rx_val,
  output logic              dev_req_valid,
  output logic              dev_req_write,
  output logic [DATA_W-1:0] dev_req_data,
  input  logic              dev_req_ready,
  input  logic [DATA_W-1:0] dev_rsp_data,
  input  logic              dev_rsp_err
);
  seq_state_t state_q;
  logic       start;

  assign start    = (state_q == SEQ_IDLE) && cmd_rdy;
  assign done     = (state_q == SEQ_XFER) && dev_req_valid && dev_req_ready;
  assign done_err = dev_rsp_err;
  assign load_rx  = ~dev_req_write & ~dev_rsp_err;
  assign rx_val   = dev_rsp_data;
  assign busy     = (state_q == SEQ_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else if (start) begin
      state_q <= SEQ_XFER;
    end else if (done) begin
      state_q <= SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_req_valid <= 1'b0;
      dev_req_write <= 1'b0;
      dev_req_data  <= '0;
    end else if (start) begin
      dev_req_valid <= 1'b1;
      dev_req_write <= cmd_dir;
      dev_req_data  <= tx_byte;
    end else if (done) begin
      dev_req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_port_ctrl.sv
module cmd_port_ctrl
  import cpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dev_req_valid,
  output logic              dev_req_write,
  output logic [DATA_W-1:0] dev_req_data,
  input  logic              dev_req_ready,
  input  logic [DATA_W-1:0] dev_rsp_data,
  input  logic              dev_rsp_err
);
  logic              busy_w;
  logic              done_w;
  logic              done_err_w;
  logic              load_rx_w;
  logic [DATA_W-1:0] rx_val_w;
  logic              cmd_rdy_w;
  logic              cmd_dir_w;
  logic [DATA_W-1:0] tx_byte_w;
  logic              err_w;

  cpc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (busy_w),
    .done       (done_w),
    .done_err   (done_err_w),
    .load_rx    (load_rx_w),
    .rx_val     (rx_val_w),
    .cmd_rdy    (cmd_rdy_w),
    .cmd_dir    (cmd_dir_w),
    .tx_byte    (tx_byte_w),
    .err_flag   (err_w)
  );

  cpc_seq #(.DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .cmd_rdy       (cmd_rdy_w),
    .cmd_dir       (cmd_dir_w),
    .tx_byte       (tx_byte_w),
    .busy          (busy_w),
    .done          (done_w),
    .done_err      (done_err_w),
    .load_rx       (load_rx_w),
    .rx_val        (rx_val_w),
    .dev_req_valid (dev_req_valid),
    .dev_req_write (dev_req_write),
    .dev_req_data  (dev_req_data),
    .dev_req_ready (dev_req_ready),
    .dev_rsp_data  (dev_rsp_data),
    .dev_rsp_err   (dev_rsp_err)
  );
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              cmd_rdy,
  input logic              err,
  input logic [DATA_W-1:0] tx_byte,
  input logic              req_valid,
  input logic              req_write,
  input logic [DATA_W-1:0] req_data,
  input logic              req_ready,
  input logic              rsp_err
);
  // R3: a pending command is picked up on the next clock
  p_go_to_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdy && !busy) |=> (busy && req_valid));

  // R3: the request is only raised while busy
  p_valid_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);

  // R6: completion drops busy and command-ready together
  p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!busy && !cmd_rdy && !req_valid));

  // R7: error reflects the failure flag seen at the handshake
  p_err_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (err == $past(rsp_err)));

  // R8: outgoing byte is frozen while a command is pending or running
  p_tx_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (busy || cmd_rdy) |=> $stable(tx_byte));

  // R10: request holds under back-pressure
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) && $stable(req_data)));
endmodule

bind cmd_port_ctrl cpc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy_w),
  .cmd_rdy   (cmd_rdy_w),
  .err       (err_w),
  .tx_byte   (tx_byte_w),
  .req_valid (dev_req_valid),
  .req_write (dev_req_write),
  .req_data  (dev_req_data),
  .req_ready (dev_req_ready),
  .rsp_err   (dev_rsp_err)
);

// File: tb/cmd_port_ctrl_tb.sv
module cmd_port_ctrl_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_we = 1'b0;
  logic          host_re = 1'b0;
  logic [1:0]    host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          dev_req_valid;
  logic          dev_req_write;
  logic [DW-1:0] dev_req_data;
  logic          dev_req_ready = 1'b0;
  logic [DW-1:0] dev_rsp_data;
  logic          dev_rsp_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cmd_port_ctrl #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_req_valid(dev_req_valid), .dev_req_write(dev_req_write),
    .dev_req_data(dev_req_data), .dev_req_ready(dev_req_ready),
    .dev_rsp_data(dev_rsp_data), .dev_rsp_err(dev_rsp_err)
  );

  // device stub
  int      stub_delay = 0;
  int      wcnt = 0;
  logic [DW-1:0] stub_data = '0;
  logic    stub_err = 1'b0;
  bit      rand_dev = 0;
  assign dev_rsp_data = stub_data;
  assign dev_rsp_err  = stub_err;

  always @(negedge clk) begin
    if (dev_req_valid === 1'b1) begin
      dev_req_ready = (wcnt >= stub_delay);
      wcnt++;
    end else begin
      dev_req_ready = 1'b0;
      wcnt = 0;
      if (rand_dev) begin
        stub_delay = $urandom % 4;
        stub_data  = DW'($urandom);
        stub_err   = (($urandom % 4) == 0);
      end
    end
  end

  // behavioural reference model
  logic          m_busy, m_rdy, m_dir, m_err, m_vld;
  logic [DW-1:0] m_tx, m_rx, m_rdata;

  always @(posedge clk) begin
    logic          n_busy, n_rdy, n_dir, n_err, n_vld;
    logic [DW-1:0] n_tx, n_rx, n_rdata;
    if (rst) begin
      m_busy = 0; m_rdy = 0; m_dir = 0; m_err = 0; m_vld = 0;
      m_tx = '0; m_rx = '0; m_rdata = '0;
      started = 1;
    end else begin
      n_busy = m_busy; n_rdy = m_rdy; n_dir = m_dir; n_err = m_err;
      n_vld = m_vld; n_tx = m_tx; n_rx = m_rx; n_rdata = m_rdata;
      if (host_re) begin
        case (host_addr)
          2'd0: n_rdata = {5'b0, m_err, m_rdy, m_busy};
          2'd1: n_rdata = {6'b0, m_rdy, m_dir};
          2'd2: n_rdata = m_tx;
          default: n_rdata = m_rx;
        endcase
      end
      if (host_we && !(m_busy || m_rdy)) begin
        if (host_addr == 2'd1) begin
          n_dir = host_wdata[0];
          n_rdy = host_wdata[1];
        end else if (host_addr == 2'd2) begin
          n_tx = host_wdata;
        end
      end
      if (!m_busy && m_rdy) begin
        n_busy = 1; n_vld = 1;
      end
      if (m_vld && dev_req_ready) begin
        n_vld = 0; n_busy = 0; n_rdy = 0; n_err = dev_rsp_err;
        if (!m_dir && !dev_rsp_err) n_rx = dev_rsp_data;
      end
      m_busy = n_busy; m_rdy = n_rdy; m_dir = n_dir; m_err = n_err;
      m_vld = n_vld; m_tx = n_tx; m_rx = n_rx; m_rdata = n_rdata;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (started && !rst && !finished) begin
      checks++;
      if (host_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R2 rdata act %h exp %h", host_rdata, m_rdata);
      end
      if (dev_req_valid !== m_vld) begin
        errors++;
        $display("FAIL R3 req_valid act %b exp %b", dev_req_valid, m_vld);
      end
      if (m_vld && dev_req_write !== m_dir) begin
        errors++;
        $display("FAIL R5 req_write act %b exp %b", dev_req_write, m_dir);
      end
      if (m_vld && dev_req_data !== m_tx) begin
        errors++;
        $display("FAIL R4 req_data act %h exp %h", dev_req_data, m_tx);
      end
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    host_re = 1; host_addr = a;
    @(negedge clk);
    host_re = 0;
    v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [DW-1:0] v;
    do rd(2'd0, v); while (v[1:0] != 2'b00);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog act %0d exp below 150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 rdata", host_rdata, '0);
    chk("R1 req_valid", {7'b0, dev_req_valid}, 8'h00);
    rd(2'd0, v); chk("R1 status", v, 8'h00);

    // R2: outgoing byte readback
    wr(2'd2, 8'hA5);
    rd(2'd2, v); chk("R2 tx readback", v, 8'hA5);

    // R3/R4/R8/R10: write command with slow device
    stub_delay = 3; stub_data = 8'h00; stub_err = 0;
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h3C);            // command-ready set, busy not yet: R8
    chk("R3 req_valid", {7'b0, dev_req_valid}, 8'h01);
    chk("R4 req_data", dev_req_data, 8'hA5);
    chk("R4 req_write", {7'b0, dev_req_write}, 8'h01);
    wr(2'd1, 8'h00);            // while busy: R8
    chk("R10 req held", {7'b0, dev_req_valid}, 8'h01);
    wait_idle();
    rd(2'd0, v); chk("R6 status clear", v, 8'h00);
    rd(2'd2, v); chk("R8 tx unchanged", v, 8'hA5);
    rd(2'd1, v); chk("R8 cmd word", v, 8'h01);

    // R5: read command
    stub_delay = 1; stub_data = 8'h5E; stub_err = 0;
    wr(2'd1, 8'h02);
    wait_idle();
    rd(2'd3, v); chk("R5 rx byte", v, 8'h5E);
    rd(2'd0, v); chk("R5 status", v, 8'h00);

    // R7: failing read
    stub_delay = 0; stub_data = 8'h77; stub_err = 1;
    wr(2'd1, 8'h02);
    wait_idle();
    rd(2'd0, v); chk("R7 error set", v, 8'h04);
    rd(2'd3, v); chk("R7 rx kept", v, 8'h5E);

    // R9: writes to status and incoming byte
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'h11);
    rd(2'd0, v); chk("R9 status", v, 8'h04);
    rd(2'd3, v); chk("R9 rx", v, 8'h5E);

    // R6: successful write clears error
    stub_delay = 2; stub_err = 0;
    wr(2'd1, 8'h03);
    wait_idle();
    rd(2'd0, v); chk("R6 error cleared", v, 8'h00);

    // random phase, checked by the reference model
    rand_dev = 1;
    for (int i = 0; i < 3000; i++) begin
      host_we    = (($urandom % 3) == 0);
      host_re    = (($urandom % 2) == 0);
      host_addr  = 2'($urandom);
      host_wdata = DW'($urandom);
      @(negedge clk);
    end
    host_we = 0; host_re = 0;
    repeat (10) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end
endmodule